// File: doc/BRIEF.md
# Three-Slot Receive Message Queue

This block buffers accepted receive messages for a CAN-style controller. Up to three messages are held in arrival order. The oldest message is always presented on a read-only head port, so software reads the message directly from that port. Software then frees the message with a one-cycle release pulse, and the next message moves up to the head. The payload is an opaque word of `MSG_W` bits. Bit-level reception, acceptance filtering and register decoding belong to other blocks.

The block reports how many messages are waiting as a two-bit binary count. It also keeps a full flag and a sticky overrun flag. Each of these sources drives its own interrupt request, and each request has its own enable input.

A lock input selects what happens when a message arrives while all three slots are occupied and no release occurs in the same cycle:
- With the lock clear, the newest stored entry is replaced by the incoming message.
- With the lock set, the incoming message is thrown away.

Top module: `rx_msg_fifo3`

## Requirements
- R1: After reset, `pend_cnt` is 0, `head_msg` is all zeros, and `full_flag`, `ovr_flag` and all three interrupt requests are 0.
- R2: A store into an empty queue with no release makes `head_msg` equal the stored word and `pend_cnt` equal 1 one cycle later.
- R3: Stores without releases raise `pend_cnt` by one each, up to 3. Releases without stores lower it by one each. Messages leave through `head_msg` in the order they were stored.
- R4: A store and a release in the same cycle with `pend_cnt` at least 1 leave `pend_cnt` unchanged and advance `head_msg` to the next message. With `pend_cnt` equal to 1, that next message is the word just stored.
- R5: A store when `pend_cnt` is 3 and there is no release is an overrun. `pend_cnt` stays 3, the head is unchanged, and `ovr_flag` is set one cycle later. `ovr_flag` holds until a `clr_ovr` pulse. A new overrun in the same cycle as the clear wins over the clear.
- R6: With `lock_en` = 0, an overrun writes the incoming word into the newest slot. After two releases, `head_msg` shows that incoming word.
- R7: With `lock_en` = 1, an overrun drops the incoming word, and the three held messages stay as they were.
- R8: `full_flag` is set on the cycle after `pend_cnt` goes from 2 to 3. It clears on a `clr_full` pulse, or when a release without a store lowers the count.
- R9: A release while `pend_cnt` is 0 changes nothing. `pend_cnt` stays 0 and no flag is set.
- R10: The three interrupt requests are combinational from state:
  - `irq_pend` = `ie_pend` AND (`pend_cnt` != 0)
  - `irq_full` = `ie_full` AND `full_flag`
  - `irq_ovr` = `ie_ovr` AND `ovr_flag`
- R11: `head_msg` reads all zeros whenever `pend_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| store_vld | input | 1 | One-cycle strobe: an accepted message is presented |
| store_msg | input | MSG_W | Message word to store |
| release_req | input | 1 | One-cycle strobe: free the head message |
| lock_en | input | 1 | 1: drop the incoming message on overrun; 0: overwrite the newest slot |
| clr_full | input | 1 | Write-one-to-clear pulse for the full flag |
| clr_ovr | input | 1 | Write-one-to-clear pulse for the overrun flag |
| ie_pend | input | 1 | Enable for the pending interrupt |
| ie_full | input | 1 | Enable for the full interrupt |
| ie_ovr | input | 1 | Enable for the overrun interrupt |
| head_msg | output | MSG_W | Oldest held message; zero when empty |
| pend_cnt | output | 2 | Number of held messages, 0 to 3 |
| full_flag | output | 1 | Queue became full |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq_pend | output | 1 | Pending interrupt request |
| irq_full | output | 1 | Full interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |

## Verification
The bench targets four corner cases, each with the fault it would expose:
- **Store and release together.** It drives this with one, two and three messages held. A design that handled the two strobes one after the other would change the count, or would show a stale head.
- **Overrun in both lock settings.** It drains the queue afterwards to see which word survived in the third slot. An off-by-one overwrite index would corrupt the head instead of the newest entry.
- **Release on an empty queue.** A pointer that moved on this release would misplace every later message.
- **Flag clearing.** It checks that clearing the full flag happens both by pulse and by release, and that the overrun flag stays set until it is explicitly cleared.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int SLOTS   = 3;
    localparam int IDX_W   = 2;
    localparam int CNT_W   = 2;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_MAX = cnt_t'(SLOTS);

    // Decoded per-cycle action of the queue
    typedef struct packed {
        logic push;      // message enters a free slot
        logic pop;       // head message leaves
        logic ovr_evt;   // message arrived with no room
        logic ovw;       // overrun replaces the newest slot
        logic full_set;  // count reaches the maximum
    } rxq_ctl_t;

    function automatic idx_t idx_next(input idx_t i);
        return (i == idx_t'(SLOTS - 1)) ? '0 : i + idx_t'(1);
    endfunction

    function automatic idx_t idx_prev(input idx_t i);
        return (i == '0) ? idx_t'(SLOTS - 1) : i - idx_t'(1);
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     store_vld,
    input  logic     release_req,
    input  logic     lock_en,
    output rxq_ctl_t ctl,
    output logic     wr_en,
    output idx_t     wr_idx,
    output idx_t     rd_idx,
    output cnt_t     cnt
);

    idx_t rd_q, wr_q;
    cnt_t cnt_q;
    logic is_empty, is_full;

    always_comb begin
        is_empty     = (cnt_q == '0);
        is_full      = (cnt_q == CNT_MAX);
        ctl.pop      = release_req && !is_empty;
        ctl.push     = store_vld && (!is_full || ctl.pop);
        ctl.ovr_evt  = store_vld && is_full && !ctl.pop;
        ctl.ovw      = ctl.ovr_evt && !lock_en;
        ctl.full_set = ctl.push && !ctl.pop && (cnt_q == CNT_MAX - cnt_t'(1));
        wr_en        = ctl.push || ctl.ovw;
        wr_idx       = ctl.push ? wr_q : idx_prev(wr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (ctl.pop)  rd_q <= idx_next(rd_q);
            if (ctl.push) wr_q <= idx_next(wr_q);
            if (ctl.push && !ctl.pop)
                cnt_q <= cnt_q + cnt_t'(1);
            else if (ctl.pop && !ctl.push)
                cnt_q <= cnt_q - cnt_t'(1);
        end
    end

    assign rd_idx = rd_q;
    assign cnt    = cnt_q;

endmodule

// File: rtl/rxq_slots.sv
module rxq_slots
    import rxq_pkg::*;
#(
    parameter int MSG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  idx_t             wr_idx,
    input  logic [MSG_W-1:0] wr_data,
    input  idx_t             rd_idx,
    input  logic             rd_valid,
    output logic [MSG_W-1:0] rd_data
);

    logic [MSG_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (wr_en && (wr_idx == idx_t'(g)))
                slot_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_valid && (rd_idx == idx_t'(i)))
                rd_data = slot_q[i];
        end
    end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rxq_ctl_t ctl,
    input  cnt_t     cnt,
    input  logic     clr_full,
    input  logic     clr_ovr,
    input  logic     ie_pend,
    input  logic     ie_full,
    input  logic     ie_ovr,
    output logic     full_flag,
    output logic     ovr_flag,
    output logic     irq_pend,
    output logic     irq_full,
    output logic     irq_ovr
);

    logic full_q, ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (ctl.full_set)
                full_q <= 1'b1;
            else if (clr_full || (ctl.pop && !ctl.push))
                full_q <= 1'b0;

            if (ctl.ovr_evt)
                ovr_q <= 1'b1;
            else if (clr_ovr)
                ovr_q <= 1'b0;
        end
    end

    assign full_flag = full_q;
    assign ovr_flag  = ovr_q;
    assign irq_pend  = ie_pend && (cnt != '0);
    assign irq_full  = ie_full && full_q;
    assign irq_ovr   = ie_ovr && ovr_q;

endmodule

// File: rtl/rx_msg_fifo3.sv
module rx_msg_fifo3
    import rxq_pkg::*;
#(
    parameter int MSG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             store_vld,
    input  logic [MSG_W-1:0] store_msg,
    input  logic             release_req,
    input  logic             lock_en,
    input  logic             clr_full,
    input  logic             clr_ovr,
    input  logic             ie_pend,
    input  logic             ie_full,
    input  logic             ie_ovr,
    output logic [MSG_W-1:0] head_msg,
    output logic [1:0]       pend_cnt,
    output logic             full_flag,
    output logic             ovr_flag,
    output logic             irq_pend,
    output logic             irq_full,
    output logic             irq_ovr
);

    rxq_ctl_t ctl;
    logic     wr_en;
    idx_t     wr_idx, rd_idx;
    cnt_t     cnt;

    rxq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .store_vld   (store_vld),
        .release_req (release_req),
        .lock_en     (lock_en),
        .ctl         (ctl),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .rd_idx      (rd_idx),
        .cnt         (cnt)
    );

    rxq_slots #(.MSG_W(MSG_W)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (store_msg),
        .rd_idx   (rd_idx),
        .rd_valid (cnt != '0),
        .rd_data  (head_msg)
    );

    rxq_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .cnt       (cnt),
        .clr_full  (clr_full),
        .clr_ovr   (clr_ovr),
        .ie_pend   (ie_pend),
        .ie_full   (ie_full),
        .ie_ovr    (ie_ovr),
        .full_flag (full_flag),
        .ovr_flag  (ovr_flag),
        .irq_pend  (irq_pend),
        .irq_full  (irq_full),
        .irq_ovr   (irq_ovr)
    );

    assign pend_cnt = cnt;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int MSG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             store_vld,
    input logic [MSG_W-1:0] store_msg,
    input logic             release_req,
    input logic             lock_en,
    input logic             clr_ovr,
    input logic [MSG_W-1:0] head_msg,
    input logic [1:0]       pend_cnt,
    input logic             full_flag,
    input logic             ovr_flag,
    input logic             ie_ovr,
    input logic             irq_ovr
);

    assert_first_store_R2: assert property (@(posedge clk) disable iff (rst)
        (store_vld && !release_req && pend_cnt == 2'd0)
        |=> (pend_cnt == 2'd1 && head_msg == $past(store_msg)));

    assert_swap_keeps_count_R4: assert property (@(posedge clk) disable iff (rst)
        (store_vld && release_req && pend_cnt != 2'd0) |=> $stable(pend_cnt));

    assert_overrun_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (store_vld && !release_req && pend_cnt == 2'd3)
        |=> (ovr_flag && pend_cnt == 2'd3 && $stable(head_msg)));

    assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !clr_ovr) |=> ovr_flag);

    assert_lock_keeps_head_R7: assert property (@(posedge clk) disable iff (rst)
        (lock_en && store_vld && !release_req && pend_cnt == 2'd3) |=> $stable(head_msg));

    assert_full_implies_three_R8: assert property (@(posedge clk) disable iff (rst)
        full_flag |-> pend_cnt == 2'd3);

    assert_empty_release_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (release_req && !store_vld && pend_cnt == 2'd0) |=> (pend_cnt == 2'd0));

    assert_irq_ovr_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq_ovr |-> (ovr_flag && ie_ovr));

    assert_empty_head_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (pend_cnt == 2'd0) |-> (head_msg == '0));

endmodule

bind rx_msg_fifo3 rxq_chk #(.MSG_W(MSG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .store_vld   (store_vld),
    .store_msg   (store_msg),
    .release_req (release_req),
    .lock_en     (lock_en),
    .clr_ovr     (clr_ovr),
    .head_msg    (head_msg),
    .pend_cnt    (pend_cnt),
    .full_flag   (full_flag),
    .ovr_flag    (ovr_flag),
    .ie_ovr      (ie_ovr),
    .irq_ovr     (irq_ovr)
);

// File: tb/rx_msg_fifo3_test.sv
`timescale 1ns/1ps
module rx_msg_fifo3_test;

    localparam int MSG_W = 32;
    localparam int NVEC  = 13;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             store_vld = 1'b0;
    logic [MSG_W-1:0] store_msg = '0;
    logic             release_req = 1'b0;
    logic             lock_en = 1'b0;
    logic             clr_full = 1'b0;
    logic             clr_ovr = 1'b0;
    logic             ie_pend = 1'b0;
    logic             ie_full = 1'b0;
    logic             ie_ovr = 1'b0;
    logic [MSG_W-1:0] head_msg;
    logic [1:0]       pend_cnt;
    logic             full_flag, ovr_flag, irq_pend, irq_full, irq_ovr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rx_msg_fifo3 #(.MSG_W(MSG_W)) uut (
        .clk(clk), .rst(rst), .store_vld(store_vld), .store_msg(store_msg),
        .release_req(release_req), .lock_en(lock_en), .clr_full(clr_full),
        .clr_ovr(clr_ovr), .ie_pend(ie_pend), .ie_full(ie_full), .ie_ovr(ie_ovr),
        .head_msg(head_msg), .pend_cnt(pend_cnt), .full_flag(full_flag),
        .ovr_flag(ovr_flag), .irq_pend(irq_pend), .irq_full(irq_full),
        .irq_ovr(irq_ovr)
    );

    // Vector: [19] store, [18] release, [17:10] msg, [9:8] exp count, [7:0] exp head
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'hA1, 2'd1, 8'hA1},   // R2 first store
        {1'b1, 1'b0, 8'hA2, 2'd2, 8'hA1},   // R3
        {1'b1, 1'b0, 8'hA3, 2'd3, 8'hA1},   // R3
        {1'b0, 1'b1, 8'h00, 2'd2, 8'hA2},   // R3 release order
        {1'b0, 1'b1, 8'h00, 2'd1, 8'hA3},   // R3
        {1'b1, 1'b1, 8'hB1, 2'd1, 8'hB1},   // R4 swap at one
        {1'b0, 1'b1, 8'h00, 2'd0, 8'h00},   // R11 empty head
        {1'b0, 1'b1, 8'h00, 2'd0, 8'h00},   // R9 empty release
        {1'b1, 1'b0, 8'hC1, 2'd1, 8'hC1},   // R2
        {1'b1, 1'b0, 8'hC2, 2'd2, 8'hC1},   // R3
        {1'b1, 1'b1, 8'hC3, 2'd2, 8'hC2},   // R4 swap at two
        {1'b0, 1'b1, 8'h00, 2'd1, 8'hC3},   // R4
        {1'b0, 1'b1, 8'h00, 2'd0, 8'h00}    // R11
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic rel, input logic [7:0] m);
        @(negedge clk);
        store_vld   = st;
        release_req = rel;
        store_msg   = {24'h0, m};
        @(negedge clk);
        store_vld   = 1'b0;
        release_req = 1'b0;
        store_msg   = '0;
    endtask

    task automatic pulse_clr(input logic f, input logic o);
        @(negedge clk);
        clr_full = f;
        clr_ovr  = o;
        @(negedge clk);
        clr_full = 1'b0;
        clr_ovr  = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 count", 64'(pend_cnt), 64'd0);
        chk("R1 head", 64'(head_msg), 64'd0);
        chk("R1 flags", 64'({full_flag, ovr_flag, irq_pend, irq_full, irq_ovr}), 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][19], VEC[i][18], VEC[i][17:10]);
            chk($sformatf("R3/R4 vec%0d count", i), 64'(pend_cnt), 64'(VEC[i][9:8]));
            chk($sformatf("R3/R4 vec%0d head", i), 64'(head_msg), 64'(VEC[i][7:0]));
        end
        chk("R9 no flags after empty release", 64'({full_flag, ovr_flag}), 64'd0);

        // R8 full flag and R10 interrupts
        ie_pend = 1'b1; ie_full = 1'b1; ie_ovr = 1'b1;
        step(1'b1, 1'b0, 8'hD1);
        chk("R10 irq_pend", 64'(irq_pend), 64'd1);
        step(1'b1, 1'b0, 8'hD2);
        chk("R8 not full at two", 64'(full_flag), 64'd0);
        step(1'b1, 1'b0, 8'hD3);
        chk("R8 full at three", 64'(full_flag), 64'd1);
        chk("R10 irq_full", 64'(irq_full), 64'd1);
        chk("R10 irq_ovr idle", 64'(irq_ovr), 64'd0);
        pulse_clr(1'b1, 1'b0);
        chk("R8 full cleared by pulse", 64'(full_flag), 64'd0);

        // R5/R6 overrun with lock off: newest slot overwritten
        lock_en = 1'b0;
        step(1'b1, 1'b0, 8'hD4);
        chk("R5 count stays three", 64'(pend_cnt), 64'd3);
        chk("R5 ovr set", 64'(ovr_flag), 64'd1);
        chk("R5 head kept", 64'(head_msg), 64'hD1);
        chk("R10 irq_ovr", 64'(irq_ovr), 64'd1);
        ie_ovr = 1'b0;
        @(negedge clk);
        chk("R10 irq_ovr masked", 64'(irq_ovr), 64'd0);
        step(1'b0, 1'b1, 8'h00);
        chk("R6 second head", 64'(head_msg), 64'hD2);
        chk("R5 ovr sticky", 64'(ovr_flag), 64'd1);
        step(1'b0, 1'b1, 8'h00);
        chk("R6 overwritten word", 64'(head_msg), 64'hD4);
        pulse_clr(1'b0, 1'b1);
        chk("R5 ovr cleared", 64'(ovr_flag), 64'd0);
        step(1'b0, 1'b1, 8'h00);
        chk("R11 drained", 64'(head_msg), 64'd0);

        // R7 overrun with lock on: incoming word dropped
        lock_en = 1'b1;
        step(1'b1, 1'b0, 8'hE1);
        step(1'b1, 1'b0, 8'hE2);
        step(1'b1, 1'b0, 8'hE3);
        step(1'b0, 1'b1, 8'h00);
        chk("R8 full cleared by release", 64'(full_flag), 64'd0);
        step(1'b1, 1'b0, 8'hE4);
        step(1'b1, 1'b0, 8'hE5);
        chk("R7 ovr set", 64'(ovr_flag), 64'd1);
        chk("R7 count", 64'(pend_cnt), 64'd3);
        chk("R7 head", 64'(head_msg), 64'hE2);
        step(1'b0, 1'b1, 8'h00);
        chk("R7 second", 64'(head_msg), 64'hE3);
        step(1'b0, 1'b1, 8'h00);
        chk("R7 third kept", 64'(head_msg), 64'hE4);

        // R4 swap at three: no overrun
        pulse_clr(1'b0, 1'b1);
        step(1'b1, 1'b0, 8'hF1);
        step(1'b1, 1'b0, 8'hF2);
        step(1'b1, 1'b1, 8'hF3);
        chk("R4 swap at three count", 64'(pend_cnt), 64'd3);
        chk("R4 swap at three head", 64'(head_msg), 64'hF1);
        chk("R4 no overrun on swap", 64'(ovr_flag), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule